// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Controller

This block holds the status and interrupt logic of a synchronous serial port that buffers both directions in FIFOs. It contains a transmit FIFO, loaded by software and drained by the shift engine, and a receive FIFO, loaded by the shift engine and drained by software. From the occupancy of both FIFOs, the push and pop strobes, and the frame-done and busy signals of the shift engine, it builds a read-only 16-bit status word. That word combines live level flags with sticky event flags. The block also drives one interrupt request, which is the OR of the event flags selected by an enable mask.

The shift engine is represented only by its handshake. It takes a transmit entry with `tx_pop`. It reports a finished frame with `frame_done` and `shift_busy`. It delivers a received frame with `rx_valid`. A frame is either one byte or one 16-bit word, selected by `word_mode`. Software clears event flags by writing ones through a single write strobe.

Top module: `spi_fifo_stat_irq`

## Requirements
- R1: During and after reset the status word reads 0x1400 and `irq` is low. Only bit 10 (TX empty) and bit 12 (RX empty) are set.
- R2: Status bit 0 (TX interrupt) sets one cycle after the TX occupancy equals `tx_thresh`. It does not set while the occupancy is above or below that value.
- R3: Status bit 1 (RX interrupt) sets one cycle after the RX occupancy becomes greater than or equal to `rx_thresh`. It stays clear below that value.
- R4: Status bit 2 (transfer end) sets one cycle after a `frame_done` pulse that arrives while the TX FIFO is empty and `shift_busy` is low. A `frame_done` with TX entries still waiting, or with the engine busy, leaves it clear.
- R5: Status bit 3 (overrun) sets one cycle after `rx_valid` arrives while the RX FIFO is full. The new frame is dropped and the stored frames are kept in order.
- R6: Status bit 8 (write overflow) sets one cycle after `tx_push` arrives while the TX FIFO is full. The pushed data is discarded.
- R7: Status bit 4 (mode fault) sets one cycle after a `mode_fault` pulse. Status bit 5 (transfer complete) sets one cycle after every `frame_done` pulse.
- R8: Status bit 9 (TX full), bit 10 (TX empty), bit 11 (RX full) and bit 12 (RX empty) follow the occupancy counters in the same cycle as the counters. Bits 6, 7 and 13 to 15 read zero.
- R9: With `clr_we` high, each event flag whose status position is 1 in `clr_data` clears on the next edge. A flag whose set condition holds in that same cycle stays set.
- R10: `irq` is high exactly when one of status bits 0 to 5 is set and its `irq_en` bit (same index) is 1. Write overflow never raises `irq`.
- R11: Both FIFOs return entries in push order, 16 deep. With `word_mode` low, bits 15:8 of every stored entry are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1: 16-bit frames, 0: byte frames |
| tx_push | input | 1 | Software writes one TX entry |
| tx_wdata | input | 16 | TX entry data |
| tx_pop | input | 1 | Shift engine takes the oldest TX entry |
| tx_rdata | output | 16 | Oldest TX entry |
| rx_valid | input | 1 | Shift engine finished receiving a frame |
| rx_wdata | input | 16 | Received frame data |
| rx_pop | input | 1 | Software reads one RX entry |
| rx_rdata | output | 16 | Oldest RX entry |
| frame_done | input | 1 | Shift engine finished shifting a TX frame |
| shift_busy | input | 1 | Shift engine is in a frame |
| mode_fault | input | 1 | Mode fault event pulse |
| tx_thresh | input | 5 | TX interrupt occupancy (exact match) |
| rx_thresh | input | 5 | RX interrupt occupancy (at least) |
| irq_en | input | 6 | Enable for status bits 0 to 5 |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 16 | Status positions to clear |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the clear-while-true race. A clear strobe must land in the same cycle as a still-valid set condition, and the set must win. The bench gets there by filling the RX FIFO past its threshold and then issuing the clear. It next drains the FIFO below the threshold and clears again, which shows the flag does drop once its condition ends. Overrun and write overflow also need exactly 16 frames in place before the extra push. The bench then drains every entry to show that the surplus frame never entered storage.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int unsigned NUM_EV  = 7;
  localparam int unsigned NUM_IRQ = 6;

  // event flag index
  localparam int unsigned EV_TXI = 0;
  localparam int unsigned EV_RXI = 1;
  localparam int unsigned EV_END = 2;
  localparam int unsigned EV_OVR = 3;
  localparam int unsigned EV_MDF = 4;
  localparam int unsigned EV_CPL = 5;
  localparam int unsigned EV_WOF = 6;

  // status word position of each event flag
  localparam int unsigned EV_STAT_POS [NUM_EV] = '{0, 1, 2, 3, 4, 5, 8};

  // status word positions of the level flags
  localparam int unsigned ST_TXF = 9;
  localparam int unsigned ST_TXE = 10;
  localparam int unsigned ST_RXF = 11;
  localparam int unsigned ST_RXE = 12;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PTR_W  = $clog2(DEPTH),
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              wr_en, rd_en, ptr_en;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign rdata = mem_q[rptr_q];

  always_comb begin
    wr_en  = push & ~full;
    rd_en  = pop & ~empty;
    ptr_en = wr_en | rd_en;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = count;
    if (wr_en) wptr_d = (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
    if (rd_en) rptr_d = (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
    if (wr_en && !rd_en) cnt_d = count + 1'b1;
    else if (rd_en && !wr_en) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      count  <= '0;
    end else if (ptr_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      count  <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wptr_q] <= wdata;
  end
endmodule

// File: rtl/sfs_flags.sv
module sfs_flags #(
  parameter int unsigned NUM_EV  = 7,
  parameter int unsigned NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EV-1:0]  ev_set,
  input  logic [NUM_EV-1:0]  ev_clr,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic [NUM_EV-1:0]  ev_q,
  output logic               irq
);
  logic [NUM_EV-1:0] ev_d;
  logic              ev_en;

  // a set in the clearing cycle wins
  always_comb begin
    ev_d  = (ev_q & ~ev_clr) | ev_set;
    ev_en = (|ev_set) | (|ev_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= '0;
    else if (ev_en) ev_q <= ev_d;
  end

  assign irq = |(ev_q[NUM_IRQ-1:0] & irq_en);
endmodule

// File: rtl/spi_fifo_stat_irq.sv
module spi_fifo_stat_irq
  import sfs_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_mode,
  input  logic               tx_push,
  input  logic [DATA_W-1:0]  tx_wdata,
  input  logic               tx_pop,
  output logic [DATA_W-1:0]  tx_rdata,
  input  logic               rx_valid,
  input  logic [DATA_W-1:0]  rx_wdata,
  input  logic               rx_pop,
  output logic [DATA_W-1:0]  rx_rdata,
  input  logic               frame_done,
  input  logic               shift_busy,
  input  logic               mode_fault,
  input  logic [CNT_W-1:0]   tx_thresh,
  input  logic [CNT_W-1:0]   rx_thresh,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               clr_we,
  input  logic [15:0]        clr_data,
  output logic [15:0]        status,
  output logic               irq
);
  localparam logic [DATA_W-1:0] BYTE_KEEP = DATA_W'(8'hFF);

  logic [DATA_W-1:0] frame_mask, tx_in, rx_in;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [NUM_EV-1:0] ev_set, ev_clr, ev_q;
  logic              unused_clr_bits;

  assign frame_mask = word_mode ? '1 : BYTE_KEEP;
  assign tx_in      = tx_wdata & frame_mask;
  assign rx_in      = rx_wdata & frame_mask;

  sfs_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_in), .pop(tx_pop),
    .rdata(tx_rdata), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  sfs_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .wdata(rx_in), .pop(rx_pop),
    .rdata(rx_rdata), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_TXI] = (tx_cnt == tx_thresh);
    ev_set[EV_RXI] = (rx_cnt >= rx_thresh);
    ev_set[EV_END] = frame_done & tx_empty & ~shift_busy;
    ev_set[EV_OVR] = rx_valid & rx_full;
    ev_set[EV_MDF] = mode_fault;
    ev_set[EV_CPL] = frame_done;
    ev_set[EV_WOF] = tx_push & tx_full;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_clr
    assign ev_clr[g] = clr_we & clr_data[EV_STAT_POS[g]];
  end

  assign unused_clr_bits = ^{clr_data[15:9], clr_data[7:6]};

  sfs_flags #(.NUM_EV(NUM_EV), .NUM_IRQ(NUM_IRQ)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
    .irq_en(irq_en), .ev_q(ev_q), .irq(irq)
  );

  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_EV; i++) status[EV_STAT_POS[i]] = ev_q[i];
    status[ST_TXF] = tx_full;
    status[ST_TXE] = tx_empty;
    status[ST_RXF] = rx_full;
    status[ST_RXE] = rx_empty;
  end
endmodule

// File: rtl/sfs_chk.sv
module sfs_chk #(
  parameter int unsigned NUM_IRQ = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_push,
  input logic               rx_valid,
  input logic               frame_done,
  input logic               shift_busy,
  input logic               mode_fault,
  input logic               clr_we,
  input logic [15:0]        clr_data,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic [15:0]        status,
  input logic               irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (status[15:13] == 3'b0) && (status[7:6] == 2'b0)); // R8
  AST_TX_LEVEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(status[9] && status[10])); // R8
  AST_RX_LEVEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(status[11] && status[12])); // R8
  AST_END_SET: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && status[10] && !shift_busy) |=> status[2]); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && status[11]) |=> status[3]); // R5
  AST_WOF_SET: assert property (@(posedge clk) disable iff (!rst_n) (tx_push && status[9]) |=> status[8]); // R6
  AST_MDF_SET: assert property (@(posedge clk) disable iff (!rst_n) mode_fault |=> status[4]); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (status[3] && !(clr_we && clr_data[3])) |=> status[3]); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) ((status[5:0] & irq_en) == '0) |-> !irq); // R10
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n) ((status[5:0] & irq_en) != '0) |-> irq); // R10
endmodule

bind spi_fifo_stat_irq sfs_chk #(.NUM_IRQ(6)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .rx_valid(rx_valid),
  .frame_done(frame_done), .shift_busy(shift_busy), .mode_fault(mode_fault),
  .clr_we(clr_we), .clr_data(clr_data), .irq_en(irq_en),
  .status(status), .irq(irq)
);

// File: tb/spi_fifo_stat_irq_tb.sv
module spi_fifo_stat_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_mode, tx_push, tx_pop, rx_valid, rx_pop;
  logic        frame_done, shift_busy, mode_fault, clr_we;
  logic [15:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata, clr_data, status;
  logic [4:0]  tx_thresh, rx_thresh;
  logic [5:0]  irq_en;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_valid(rx_valid), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .frame_done(frame_done), .shift_busy(shift_busy), .mode_fault(mode_fault),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_en(irq_en),
    .clr_we(clr_we), .clr_data(clr_data), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [15:0] d);
    tx_push = 1'b1; tx_wdata = d; @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic push_rx(input logic [15:0] d);
    rx_valid = 1'b1; rx_wdata = d; @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pop_tx();
    tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pop_rx();
    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic clear(input logic [15:0] m);
    clr_we = 1'b1; clr_data = m; @(negedge clk); clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic pulse_frame(input logic busy);
    shift_busy = busy; frame_done = 1'b1; @(negedge clk);
    frame_done = 1'b0; shift_busy = 1'b0;
  endtask

  task automatic drain_all();
    for (int i = 0; i < 17; i++) begin
      if (!status[10]) pop_tx();
      if (!status[12]) pop_rx();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 status in reset", status, 16'h1400);
    check("R1 irq in reset", {15'b0, irq}, 16'h0);
    rst_n = 1'b1;
    idle(); idle();
    check("R1 status after reset", status, 16'h1400);
    check("R1 irq after reset", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_tx_threshold();
    clear(16'hFFFF);
    tx_thresh = 5'd3;
    for (int i = 1; i <= 4; i++) begin
      push_tx(16'h0100 + 16'(i));
      idle();
      check($sformatf("R2 TX flag at count %0d", i), {15'b0, status[0]}, (i >= 3) ? 16'h1 : 16'h0);
    end
    clear(16'h0001);
    check("R2 TX flag stays clear above threshold", {15'b0, status[0]}, 16'h0);
    pop_tx();
    idle();
    check("R2 TX flag sets on equality while popping", {15'b0, status[0]}, 16'h1);
    drain_all();
  endtask

  task automatic t_rx_threshold();
    clear(16'hFFFF);
    rx_thresh = 5'd4;
    for (int i = 1; i <= 5; i++) begin
      push_rx(16'h0200 + 16'(i));
      idle();
      check($sformatf("R3 RX flag at count %0d", i), {15'b0, status[1]}, (i >= 4) ? 16'h1 : 16'h0);
    end
    clear(16'h0002);
    check("R9 RX flag kept when cleared while condition holds", {15'b0, status[1]}, 16'h1);
    pop_rx(); pop_rx();
    clear(16'h0002);
    check("R9 RX flag clears below threshold", {15'b0, status[1]}, 16'h0);
    drain_all();
  endtask

  task automatic t_tx_overflow();
    clear(16'hFFFF);
    word_mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      push_tx(16'hA000 + 16'(i));
      if (i == 14) check("R8 TX not full at 15", {15'b0, status[9]}, 16'h0);
    end
    check("R8 TX full at 16", {14'b0, status[10:9]}, 16'h1);
    push_tx(16'hDEAD);
    idle();
    check("R6 write overflow flag", {15'b0, status[8]}, 16'h1);
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R6 R11 TX order entry %0d", i), tx_rdata, 16'hA000 + 16'(i));
      pop_tx();
    end
    check("R8 TX empty after drain", {14'b0, status[10:9]}, 16'h2);
  endtask

  task automatic t_rx_overrun();
    clear(16'hFFFF);
    for (int i = 0; i < 16; i++) push_rx(16'h5000 + 16'(i));
    check("R8 RX full at 16", {14'b0, status[12:11]}, 16'h1);
    push_rx(16'hBEEF);
    idle();
    check("R5 overrun flag", {15'b0, status[3]}, 16'h1);
    for (int i = 0; i < 16; i++) begin
      check($sformatf("R5 R11 RX order entry %0d", i), rx_rdata, 16'h5000 + 16'(i));
      pop_rx();
    end
    check("R8 RX empty after drain", {14'b0, status[12:11]}, 16'h2);
    check("R8 reserved bits zero", status & 16'hE0C0, 16'h0);
  endtask

  task automatic t_xfer_end();
    clear(16'hFFFF);
    push_tx(16'h0042);
    pulse_frame(1'b0);
    idle();
    check("R4 no transfer end with TX data waiting", {15'b0, status[2]}, 16'h0);
    check("R7 transfer complete on frame done", {15'b0, status[5]}, 16'h1);
    pop_tx();
    pulse_frame(1'b1);
    idle();
    check("R4 no transfer end while engine busy", {15'b0, status[2]}, 16'h0);
    pulse_frame(1'b0);
    idle();
    check("R4 transfer end on last frame", {15'b0, status[2]}, 16'h1);
    mode_fault = 1'b1; @(negedge clk); mode_fault = 1'b0;
    idle();
    check("R7 mode fault flag", {15'b0, status[4]}, 16'h1);
  endtask

  task automatic t_irq();
    clear(16'hFFFF);
    irq_en = 6'b000000;
    pulse_frame(1'b0);
    idle();
    check("R10 irq masked", {15'b0, irq}, 16'h0);
    irq_en = 6'b100000; #1;
    check("R10 irq from transfer complete", {15'b0, irq}, 16'h1);
    irq_en = 6'b000001; #1;
    check("R10 irq with unrelated enable", {15'b0, irq}, 16'h0);
    clear(16'h0020);
    irq_en = 6'b100100; #1;
    check("R10 irq from transfer end after partial clear", {15'b0, irq}, 16'h1);
    clear(16'h0004);
    check("R9 R10 irq drops after clear", {15'b0, irq}, 16'h0);
    push_tx(16'h0);
    for (int i = 0; i < 16; i++) push_tx(16'h0);
    irq_en = 6'b111111; clear(16'h003F);
    check("R10 write overflow does not raise irq", {15'b0, irq}, 16'h0);
    check("R6 write overflow flag set", {15'b0, status[8]}, 16'h1);
    irq_en = 6'b000000;
    drain_all();
  endtask

  task automatic t_byte_mode();
    clear(16'hFFFF);
    word_mode = 1'b0;
    push_tx(16'h1234);
    check("R11 TX byte mode upper zero", tx_rdata, 16'h0034);
    push_rx(16'hABCD);
    check("R11 RX byte mode upper zero", rx_rdata, 16'h00CD);
    word_mode = 1'b1;
    drain_all();
  endtask

  initial begin
    rst_n = 1'b0; word_mode = 1'b1;
    tx_push = 1'b0; tx_pop = 1'b0; rx_valid = 1'b0; rx_pop = 1'b0;
    frame_done = 1'b0; shift_busy = 1'b0; mode_fault = 1'b0;
    clr_we = 1'b0; clr_data = '0; tx_wdata = '0; rx_wdata = '0;
    tx_thresh = 5'd3; rx_thresh = 5'd4; irq_en = '0;
    @(negedge clk);
    t_reset();
    t_tx_threshold();
    t_rx_threshold();
    t_tx_overflow();
    t_rx_overrun();
    t_xfer_end();
    t_irq();
    t_byte_mode();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule